// File: doc/BRIEF.md
# Presettable Cascadable Counter

This block is a small synchronous up-counter whose register can be forced to zero, preset from a data bus, advanced by one, or held. All register bits change together on the rising clock edge. Two count enables must both be high for the count to advance. Only the second of them, the carry-gating enable, qualifies the carry output. That output is high when the count sits at its terminal value, so instances can be chained: the carry of one stage drives the carry-gating enable of the next, and the chain forms one wide synchronous counter with no added logic.

Two elaboration options select the variant. `DECADE` picks counting modulo ten instead of the full binary range. `ASYNC_CLR` picks a clear that acts at once instead of one that waits for the next clock edge. In decade mode, a count above nine that was preset from the data bus keeps stepping up by one until it wraps to zero. The carry never fires from such a value.

Top module: `presettable_counter`

## Requirements
- R1: A low `load_n` with `clr_n` high copies `din` into `q` at the next rising edge, whatever `en_p` and `en_t` are.
- R2: With `clr_n` and `load_n` high, `q` advances by one at a rising edge only when `en_p` and `en_t` are both high; otherwise it keeps its value.
- R3: At a rising edge, clear takes precedence over load, and load takes precedence over counting.
- R4: With `ASYNC_CLR`=0, a low `clr_n` leaves `q` unchanged until the next rising edge, and that edge sets `q` to 0.
- R5: With `ASYNC_CLR`=1, a low `clr_n` sets `q` to 0 at once, with no clock edge, and holds it at 0 while low.
- R6: The terminal value is 15 in binary mode (`DECADE`=0) and 9 in decade mode (`DECADE`=1); counting from the terminal value gives 0.
- R7: `carry` is high exactly when `en_t` is high and `q` equals the terminal value; `en_p` has no effect on `carry`.
- R8: In decade mode, a count of 10 to 15 steps up by one on each enabled edge, with 15 going to 0, and `carry` stays low in all of those states.
- R9: Two binary instances, the second counting only when the first's `carry` is high, form an 8-bit counter that counts 0 to 255 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; synchronous or asynchronous according to `ASYNC_CLR` |
| load_n | input | 1 | Active-low synchronous preset from `din` |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates `carry` |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| carry | output | 1 | High when `en_t` is high and `q` is at the terminal value |

## Verification
The bench builds three configurations. The default binary counter with synchronous clear is run through the vector table, which covers mode precedence, enable gating and carry gating. A decade counter with asynchronous clear brings the 9-to-0 wrap, the clear that acts between edges, and the recovery from preset values 10 to 15 within reach. Two binary instances chained through the carry are counted past 255 to show the wide counter rolling over cleanly.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
   typedef enum logic [1:0] {
      CNT_CLEAR = 2'd0,
      CNT_LOAD  = 2'd1,
      CNT_STEP  = 2'd2,
      CNT_HOLD  = 2'd3
   } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
   import cnt_pkg::*;
#(
   parameter bit SYNC_CLR = 1'b1
) (
   input  logic    clr_n,
   input  logic    load_n,
   input  logic    en_p,
   input  logic    en_t,
   output cnt_op_e op
);
   logic clr_act;

   generate
      if (SYNC_CLR) begin : g_sync
         assign clr_act = ~clr_n;
      end else begin : g_async
         // the register clears itself; the decoder never selects it
         assign clr_act = 1'b0;
      end
   endgenerate

   always_comb begin
      if (clr_act)            op = CNT_CLEAR;
      else if (!load_n)       op = CNT_LOAD;
      else if (en_p && en_t)  op = CNT_STEP;
      else                    op = CNT_HOLD;
   end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
   import cnt_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter logic [WIDTH-1:0] TERM = '1
) (
   input  cnt_op_e          op,
   input  logic [WIDTH-1:0] q,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] d
);
   logic [WIDTH-1:0] q_inc;
   assign q_inc = q + 1'b1;

   always_comb begin
      unique case (op)
         CNT_CLEAR: d = '0;
         CNT_LOAD:  d = din;
         CNT_STEP:  d = (q == TERM) ? '0 : q_inc;
         default:   d = q;
      endcase
   end
endmodule

// File: rtl/cnt_term.sv
module cnt_term #(
   parameter int unsigned WIDTH = 4,
   parameter logic [WIDTH-1:0] TERM = '1
) (
   input  logic [WIDTH-1:0] q,
   input  logic             en_t,
   output logic             carry
);
   // decoded from register state only
   assign carry = en_t & (q == TERM);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
   import cnt_pkg::*;
#(
   parameter int unsigned WIDTH     = 4,
   parameter bit          DECADE    = 1'b0,
   parameter bit          ASYNC_CLR = 1'b0
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_n,
   input  logic             en_p,
   input  logic             en_t,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             carry
);
   localparam int unsigned TERM_I = DECADE ? 9 : ((1 << WIDTH) - 1);
   localparam logic [WIDTH-1:0] TERM = TERM_I[WIDTH-1:0];

   generate
      if (WIDTH < 1 || WIDTH > 30) begin : g_bad_width
         $error("presettable_counter: WIDTH out of range");
      end
      if (DECADE && WIDTH < 4) begin : g_bad_decade
         $error("presettable_counter: decade mode needs WIDTH >= 4");
      end
   endgenerate

   cnt_op_e          op;
   logic [WIDTH-1:0] d;
   logic [WIDTH-1:0] q_r;

   cnt_ctrl #(.SYNC_CLR(!ASYNC_CLR)) u_ctrl (
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (en_t),
      .op     (op)
   );

   cnt_next #(.WIDTH(WIDTH), .TERM(TERM)) u_next (
      .op  (op),
      .q   (q_r),
      .din (din),
      .d   (d)
   );

   generate
      if (ASYNC_CLR) begin : g_areg
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) q_r <= '0;
            else        q_r <= d;
         end
      end else begin : g_sreg
         always_ff @(posedge clk) begin
            q_r <= d;
         end
      end
   endgenerate

   cnt_term #(.WIDTH(WIDTH), .TERM(TERM)) u_term (
      .q     (q_r),
      .en_t  (en_t),
      .carry (carry)
   );

   assign q = q_r;
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
   parameter int unsigned WIDTH     = 4,
   parameter bit          DECADE    = 1'b0,
   parameter bit          ASYNC_CLR = 1'b0
) (
   input logic             clk,
   input logic             clr_n,
   input logic             load_n,
   input logic             en_p,
   input logic             en_t,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] q,
   input logic             carry
);
   localparam int unsigned LAST_I = DECADE ? 9 : ((1 << WIDTH) - 1);
   localparam logic [WIDTH-1:0] LAST = LAST_I[WIDTH-1:0];

   logic             armed;
   logic [WIDTH-1:0] q_plus;
   assign q_plus = q + 1'b1;

   always_ff @(posedge clk) begin
      if (!clr_n) armed <= 1'b1;
   end

   // R1
   load_copy_chk: assert property (@(posedge clk) disable iff (armed !== 1'b1 || !clr_n)
      !load_n |=> q == $past(din));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (armed !== 1'b1 || !clr_n)
      (load_n && en_p && en_t) |=> q == (($past(q) == LAST) ? '0 : $past(q_plus)));

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (armed !== 1'b1 || !clr_n)
      (load_n && !(en_p && en_t)) |=> $stable(q));

   // R7
   carry_src_chk: assert property (@(posedge clk) disable iff (armed !== 1'b1)
      carry |-> (en_t && q == LAST));

   // R7
   carry_gate_chk: assert property (@(posedge clk) disable iff (armed !== 1'b1)
      !en_t |-> !carry);

   generate
      if (ASYNC_CLR) begin : g_aclr
         // R5
         clear_now_chk: assert property (@(posedge clk) disable iff (armed !== 1'b1)
            !clr_n |-> q == '0);
      end else begin : g_sclr
         // R4
         clear_edge_chk: assert property (@(posedge clk) disable iff (armed !== 1'b1)
            !clr_n |=> q == '0);
      end
   endgenerate
endmodule

bind presettable_counter cnt_checker #(
   .WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_chk (
   .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
   .din(din), .q(q), .carry(carry)
);

// File: tb/tb_presettable_counter.sv
module tb_presettable_counter;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 11;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // binary, synchronous clear
   logic       clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
   logic [3:0] din = '0, q;
   logic       carry;

   // decade, asynchronous clear
   logic       d_clr_n = 1'b0, d_load_n = 1'b1, d_en_p = 1'b0, d_en_t = 1'b0;
   logic [3:0] d_din = '0, d_q;
   logic       d_carry;

   // cascade of two binary stages
   logic       c_clr_n = 1'b0;
   logic [3:0] lo_q, hi_q;
   logic       lo_carry, hi_carry;

   presettable_counter dut (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
      .din(din), .q(q), .carry(carry));

   presettable_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b1)) dut_dec (
      .clk(clk), .clr_n(d_clr_n), .load_n(d_load_n), .en_p(d_en_p), .en_t(d_en_t),
      .din(d_din), .q(d_q), .carry(d_carry));

   presettable_counter dut_lo (
      .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_p(1'b1), .en_t(1'b1),
      .din(4'd0), .q(lo_q), .carry(lo_carry));

   presettable_counter dut_hi (
      .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_p(1'b1), .en_t(lo_carry),
      .din(4'd0), .q(hi_q), .carry(hi_carry));

   // {clr_n, load_n, en_p, en_t, din, expected q, expected carry}
   localparam logic [12:0] VEC [NVEC] = '{
      13'b0_1_1_1_0000_0000_0,  // R4 clear
      13'b1_0_1_1_1110_1110_0,  // R1 preset 14
      13'b1_1_1_1_0000_1111_1,  // R7 reach 15, carry
      13'b1_1_1_1_0000_0000_0,  // R6 wrap to 0
      13'b1_1_0_1_0000_0000_0,  // R2 en_p low holds
      13'b1_0_0_0_1111_1111_0,  // R1 preset with enables low
      13'b1_1_0_1_0000_1111_1,  // R7 carry ignores en_p
      13'b1_1_1_0_0000_1111_0,  // R2 en_t low holds, R7 gates carry
      13'b0_0_1_1_0101_0000_0,  // R3 clear beats load
      13'b1_0_1_1_1001_1001_0,  // R3 load beats count
      13'b1_1_1_1_0000_1010_0   // R2 count 9 to 10
   };

   function automatic string vtag(int i);
      case (i)
         0: return "R4";
         1, 5: return "R1";
         2, 6: return "R7";
         3: return "R6";
         8, 9: return "R3";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      tick();
      chk("R4", int'(q), 0);
      chk("R5", int'(d_q), 0);

      // table for the binary, synchronous-clear instance
      for (int i = 0; i < NVEC; i++) begin
         {clr_n, load_n, en_p, en_t, din} = VEC[i][12:5];
         tick();
         chk(vtag(i), int'(q), int'(VEC[i][4:1]));
         chk(vtag(i), int'(carry), int'(VEC[i][0]));
      end

      // R4: a synchronous clear waits for the edge
      {clr_n, load_n, en_p, en_t, din} = {4'b1011, 4'd7};
      tick();
      clr_n = 1'b0;
      load_n = 1'b1;
      #1;
      chk("R4", int'(q), 7);
      tick();
      chk("R4", int'(q), 0);
      clr_n = 1'b1;

      // decade instance
      d_clr_n = 1'b1;
      {d_load_n, d_en_p, d_en_t, d_din} = {3'b011, 4'd8};
      tick();
      chk("R1", int'(d_q), 8);
      d_load_n = 1'b1;
      tick();
      chk("R6", int'(d_q), 9);
      chk("R7", int'(d_carry), 1);
      tick();
      chk("R6", int'(d_q), 0);
      chk("R7", int'(d_carry), 0);

      // R8: recovery from a preset above nine
      {d_load_n, d_din} = {1'b0, 4'd12};
      tick();
      chk("R8", int'(d_q), 12);
      chk("R8", int'(d_carry), 0);
      d_load_n = 1'b1;
      for (int v = 13; v <= 16; v++) begin
         tick();
         chk("R8", int'(d_q), v % 16);
         chk("R8", int'(d_carry), 0);
      end
      tick();
      chk("R8", int'(d_q), 1);

      // R5: asynchronous clear between edges
      d_en_p = 1'b0;
      #2;
      d_clr_n = 1'b0;
      #1;
      chk("R5", int'(d_q), 0);
      tick();
      chk("R5", int'(d_q), 0);
      d_clr_n = 1'b1;

      // R9: 8-bit cascade across rollover
      tick();
      c_clr_n = 1'b1;
      chk("R9", int'({hi_q, lo_q}), 0);
      for (int n = 1; n <= 300; n++) begin
         tick();
         chk("R9", int'({hi_q, lo_q}), n % 256);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule